// File: doc/BRIEF.md
# Soft-Reset Handshake Sequencer

This block is a small bus master that brings a peripheral out of soft reset. The peripheral exposes one control word at three addresses: the plain word, a "set" alias (every 1 in the written data sets that bit) and a "clear" alias (every 1 clears that bit). Two bits of that word matter here: a soft-reset bit at position 31 and a clock-gate bit at position 30. A pulse on `start` makes the block run a fixed five-step write/poll procedure on those bits. It then reports success with a one-cycle `done` or failure with a one-cycle `error`.

Each step writes a one-hot mask to one of the aliases. Most steps then wait a fixed settle interval and read the plain word again and again until the watched bit holds the wanted value. Every poll loop is bounded. If a loop runs out of reads, the procedure stops at once and flags the error. The bus port is a plain request/acknowledge master: address, write flag and write data stay stable while the request waits for its acknowledge, and read data is taken in the acknowledge cycle.

Top module: `softResetSequencer`

## Requirements
- R1: While reset is held, `busy`, `done`, `error` and `busReq` are all 0.
- R2: The first step writes data 0x8000_0000 (soft-reset bit, position 31) to BASE_ADDR+0x8, the clear alias. After the settle interval it polls until read data bit 31 is 0.
- R3: The second step writes 0x4000_0000 (clock-gate bit, position 30) to BASE_ADDR+0x8. Its request follows the previous acknowledge with no idle cycle, and it does no read.
- R4: The third step writes 0x8000_0000 to BASE_ADDR+0x4, the set alias. After the settle interval it polls until read data bit 30 is 1.
- R5: The fourth step writes 0x8000_0000 to BASE_ADDR+0x8 and polls until bit 31 is 0. The fifth step writes 0x4000_0000 to BASE_ADDR+0x8 and polls until bit 30 is 0. Each waits the settle interval before its first read.
- R6: Each poll loop makes at most POLL_LIMIT reads (default 1024), issued back to back. A condition first met on the last allowed read still counts as success.
- R7: When a poll loop ends unmet, `error` pulses, no later step is issued and the bus stays idle.
- R8: A request holds `busAddr`, `busWrite` and `busWdata` stable until `busAck`. Polls are reads (`busWrite`=0) at BASE_ADDR.
- R9: `done` and `error` are single-cycle pulses, never high together. Each appears in the first cycle in which `busy` is low after the final acknowledge.
- R10: `busy` rises in the cycle after an accepted `start` and stays high until the end of the sequence. A `start` while busy is ignored, and no request is made while idle.
- R11: Between a settled write's acknowledge and the first poll read there are exactly SETTLE_CYCLES cycles (default 16) with `busReq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the sequence when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| error | output | 1 | One-cycle pulse: a poll loop timed out |
| busReq | output | 1 | Bus request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Bus acknowledge, completes the transfer this cycle |
| busRdata | input | DATA_W | Read data, valid with `busAck` on a read |

## Verification
A wrong step index or a wrong alias choice shows up at the next acknowledged transfer as a wrong address or mask, so it is caught within one transfer. A settle or poll counter that is off by one changes the count of idle cycles before the first read, or the number of reads before `error`. This shows up at the first read or at the end of the loop. A wrong state in the control machine shows up in the same cycle as a mismatch in `busy`, `done` or `error`, or as a request made while idle.

// File: rtl/srsPkg.sv
package srsPkg;

  localparam int unsigned NUM_STEPS = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_READ
  } srsStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic stepClr;
    logic stepAdv;
    logic settleLoad;
    logic settleDec;
    logic pollClr;
    logic pollInc;
  } srsStrobeT;

  // Static description of one step of the procedure
  typedef struct packed {
    logic useSet;     // 1: set alias, 0: clear alias
    logic wrGate;     // 1: clock-gate mask, 0: soft-reset mask
    logic hasSettle;  // wait before polling
    logic hasPoll;    // poll after the write
    logic pollGate;   // 1: watch clock-gate bit, 0: soft-reset bit
    logic pollVal;    // value that ends the poll
  } srsStepT;

  function automatic srsStepT stepInfo(input logic [2:0] idx);
    srsStepT s;
    case (idx)
      3'd1:    s = '{useSet: 1'b0, wrGate: 1'b1, hasSettle: 1'b0, hasPoll: 1'b0, pollGate: 1'b0, pollVal: 1'b0};
      3'd2:    s = '{useSet: 1'b1, wrGate: 1'b0, hasSettle: 1'b1, hasPoll: 1'b1, pollGate: 1'b1, pollVal: 1'b1};
      3'd3:    s = '{useSet: 1'b0, wrGate: 1'b0, hasSettle: 1'b1, hasPoll: 1'b1, pollGate: 1'b0, pollVal: 1'b0};
      3'd4:    s = '{useSet: 1'b0, wrGate: 1'b1, hasSettle: 1'b1, hasPoll: 1'b1, pollGate: 1'b1, pollVal: 1'b0};
      default: s = '{useSet: 1'b0, wrGate: 1'b0, hasSettle: 1'b1, hasPoll: 1'b1, pollGate: 1'b0, pollVal: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/srsDatapath.sv
module srsDatapath
  import srsPkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned SET_OFS       = 4,
  parameter int unsigned CLR_OFS       = 8,
  parameter int unsigned SRST_BIT      = 31,
  parameter int unsigned GATE_BIT      = 30,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned POLL_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  srsStrobeT         strb,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              settleDone,
  output logic              pollLast,
  output logic              condMet,
  output logic              hasSettle,
  output logic              hasPoll,
  output logic              lastStep
);

  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] SRST_MASK = ONE << SRST_BIT;
  localparam logic [DATA_W-1:0] GATE_MASK = ONE << GATE_BIT;
  localparam logic [ADDR_W-1:0] SET_ADDR  = BASE_ADDR + ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = BASE_ADDR + ADDR_W'(CLR_OFS);

  logic [2:0]    stepIdx;
  logic [SW-1:0] settleCnt;
  logic [PW-1:0] pollCnt;
  srsStepT       cur;
  logic [DATA_W-1:0] watchMask;

  assign cur = stepInfo(stepIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strb.stepClr) begin
      stepIdx <= '0;
    end else if (strb.stepAdv) begin
      stepIdx <= stepIdx + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.settleLoad) begin
      settleCnt <= SW'(SETTLE_CYCLES - 1);
    end else if (strb.settleDec) begin
      settleCnt <= settleCnt - SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (strb.pollClr) begin
      pollCnt <= '0;
    end else if (strb.pollInc) begin
      pollCnt <= pollCnt + PW'(1);
    end
  end

  assign busAddr    = !busWrite ? BASE_ADDR : (cur.useSet ? SET_ADDR : CLR_ADDR);
  assign busWdata   = cur.wrGate ? GATE_MASK : SRST_MASK;
  assign watchMask  = cur.pollGate ? GATE_MASK : SRST_MASK;
  assign condMet    = ((busRdata & watchMask) != '0) == cur.pollVal;
  assign settleDone = (settleCnt == '0);
  assign pollLast   = (pollCnt == PW'(POLL_LIMIT - 1));
  assign hasSettle  = cur.hasSettle;
  assign hasPoll    = cur.hasPoll;
  assign lastStep   = (stepIdx == 3'(NUM_STEPS - 1));

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(POLL_LIMIT)); // R6
  AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt < SW'(SETTLE_CYCLES)); // R11
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < 3'(NUM_STEPS)); // R7

endmodule

// File: rtl/srsCtrl.sv
module srsCtrl
  import srsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busAck,
  input  logic      settleDone,
  input  logic      pollLast,
  input  logic      condMet,
  input  logic      hasSettle,
  input  logic      hasPoll,
  input  logic      lastStep,
  output srsStrobeT strb,
  output logic      busReq,
  output logic      busWrite,
  output logic      busy,
  output logic      done,
  output logic      error
);

  srsStateT stateQ, stateD;
  logic     finOk, finErr;

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    busReq   = 1'b0;
    busWrite = 1'b0;
    finOk    = 1'b0;
    finErr   = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.stepClr = 1'b1;
          stateD       = ST_WRITE;
        end
      end
      ST_WRITE: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        if (busAck) begin
          if (hasSettle) begin
            strb.settleLoad = 1'b1;
            stateD          = ST_SETTLE;
          end else if (hasPoll) begin
            strb.pollClr = 1'b1;
            stateD       = ST_READ;
          end else if (lastStep) begin
            finOk  = 1'b1;
            stateD = ST_IDLE;
          end else begin
            strb.stepAdv = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (!settleDone) begin
          strb.settleDec = 1'b1;
        end else if (hasPoll) begin
          strb.pollClr = 1'b1;
          stateD       = ST_READ;
        end else if (lastStep) begin
          finOk  = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strb.stepAdv = 1'b1;
          stateD       = ST_WRITE;
        end
      end
      ST_READ: begin
        busReq = 1'b1;
        if (busAck) begin
          if (condMet) begin
            if (lastStep) begin
              finOk  = 1'b1;
              stateD = ST_IDLE;
            end else begin
              strb.stepAdv = 1'b1;
              stateD       = ST_WRITE;
            end
          end else if (pollLast) begin
            finErr = 1'b1;
            stateD = ST_IDLE;
          end else begin
            strb.pollInc = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= finOk;
      error  <= finErr;
    end
  end

  assign busy = (stateQ != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !error); // R9
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busy); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWrite))); // R8
  AST_ERR_AFTER_POLL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(busReq && !busWrite && busAck)); // R7

endmodule

// File: rtl/softResetSequencer.sv
module softResetSequencer
  import srsPkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8002_4000,
  parameter int unsigned SET_OFS       = 4,
  parameter int unsigned CLR_OFS       = 8,
  parameter int unsigned SRST_BIT      = 31,
  parameter int unsigned GATE_BIT      = 30,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned POLL_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  srsStrobeT strb;
  logic settleDone, pollLast, condMet, hasSettle, hasPoll, lastStep;

  srsCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .busAck     (busAck),
    .settleDone (settleDone),
    .pollLast   (pollLast),
    .condMet    (condMet),
    .hasSettle  (hasSettle),
    .hasPoll    (hasPoll),
    .lastStep   (lastStep),
    .strb       (strb),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  srsDatapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .BASE_ADDR     (BASE_ADDR),
    .SET_OFS       (SET_OFS),
    .CLR_OFS       (CLR_OFS),
    .SRST_BIT      (SRST_BIT),
    .GATE_BIT      (GATE_BIT),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .POLL_LIMIT    (POLL_LIMIT)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWrite   (busWrite),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .settleDone (settleDone),
    .pollLast   (pollLast),
    .condMet    (condMet),
    .hasSettle  (hasSettle),
    .hasPoll    (hasPoll),
    .lastStep   (lastStep)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> ($stable(busAddr) && $stable(busWdata))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busReq); // R10

endmodule

// File: tb/softResetSequencer_test.sv
`timescale 1ns/1ps
module softResetSequencer_test;

  localparam logic [31:0] TB_BASE   = 32'h4001_2000;
  localparam int          TB_SETTLE = 16;
  localparam int          TB_POLL   = 1024;
  localparam logic [31:0] SRST_M    = 32'h8000_0000;
  localparam logic [31:0] GATE_M    = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, error, busReq, busWrite, busAck;
  logic [31:0] busAddr, busWdata, busRdata;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // peripheral configuration
  logic [31:0] cfgInit = 32'hC000_0000;
  int          cfgSrstLag = 0;
  int          cfgGateLag = 0;
  bit          stallMode = 0;

  always #4 clk = ~clk;

  softResetSequencer #(
    .BASE_ADDR     (TB_BASE),
    .SETTLE_CYCLES (TB_SETTLE),
    .POLL_LIMIT    (TB_POLL)
  ) uut (
    .clk (clk), .rstN (rstN), .start (start),
    .busy (busy), .done (done), .error (error),
    .busReq (busReq), .busWrite (busWrite), .busAddr (busAddr),
    .busWdata (busWdata), .busAck (busAck), .busRdata (busRdata)
  );

  // ---------------- peripheral model ----------------
  logic [31:0] periReg;
  int          holdCnt;
  bit          gateArm;
  int          gateCnt;
  logic [7:0]  lfsr;

  assign busAck   = busReq && (!stallMode || lfsr[0]);
  assign busRdata = periReg | ((holdCnt > 0) ? SRST_M : 32'h0)
                            | ((gateArm && gateCnt == 0) ? GATE_M : 32'h0);

  always @(posedge clk) begin
    if (!rstN) begin
      periReg <= 32'h0; holdCnt <= 0; gateArm <= 0; gateCnt <= 0; lfsr <= 8'hA5;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (start && !busy) begin
        periReg <= cfgInit; holdCnt <= 0; gateArm <= 0; gateCnt <= 0;
      end else if (busReq && busAck) begin
        if (busWrite) begin
          if (busAddr == TB_BASE + 32'h4) begin
            periReg <= periReg | busWdata;
            if (busWdata[31]) begin gateArm <= 1; gateCnt <= cfgGateLag; end
          end else if (busAddr == TB_BASE + 32'h8) begin
            periReg <= periReg & ~busWdata;
            if (busWdata[31]) holdCnt <= cfgSrstLag;
          end
        end else begin
          if (holdCnt > 0) holdCnt <= holdCnt - 1;
          if (gateArm) begin
            if (gateCnt == 0) begin periReg[30] <= 1'b1; gateArm <= 0; end
            else gateCnt <= gateCnt - 1;
          end
        end
      end
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [31:0] stepAddr(int s);
    return (s == 2) ? TB_BASE + 32'h4 : TB_BASE + 32'h8;
  endfunction
  function automatic logic [31:0] stepData(int s);
    return (s == 1 || s == 4) ? GATE_M : SRST_M;
  endfunction
  function automatic bit stepMet(int s, logic [31:0] d);
    case (s)
      0, 3:    return d[31] == 1'b0;
      2:       return d[30] == 1'b1;
      default: return d[30] == 1'b0;
    endcase
  endfunction
  function automatic string stepTag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  bit mBusy = 0, mRead = 0, startPend = 0;
  int mStep = 0, mReads = 0, gap = 0, gapExp = 0, pend = 0;

  task automatic checkXfer();
    vectors++;
    if (!mRead) begin
      if (busWrite !== 1'b1 || busAddr !== stepAddr(mStep) || busWdata !== stepData(mStep) || gap != gapExp) begin
        fails++;
        $display("FAIL %s write step %0d: wr=%b addr=%h data=%h gap=%0d, expected wr=1 addr=%h data=%h gap=%0d",
                 stepTag(mStep), mStep, busWrite, busAddr, busWdata, gap, stepAddr(mStep), stepData(mStep), gapExp);
      end
      gap = 0;
      if (mStep != 1) begin mRead = 1; mReads = 0; gapExp = TB_SETTLE; end
      else begin mStep++; gapExp = 0; end
    end else begin
      if (busWrite !== 1'b0 || busAddr !== TB_BASE || gap != gapExp) begin
        fails++;
        $display("FAIL %s read step %0d (read %0d): wr=%b addr=%h gap=%0d, expected wr=0 addr=%h gap=%0d",
                 (mReads == 0) ? "R11" : "R6", mStep, mReads, busWrite, busAddr, gap, TB_BASE, gapExp);
      end
      mReads++; gap = 0; gapExp = 0;
      if (stepMet(mStep, busRdata)) begin
        if (mStep == 4) pend = 1;
        else begin mStep++; mRead = 0; end
      end else if (mReads == TB_POLL) begin
        pend = 2;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expDone, expErr;
      expDone = (pend == 1);
      expErr  = (pend == 2);
      if (pend != 0) begin mBusy = 0; pend = 0; end
      if (startPend) begin
        mBusy = 1; startPend = 0; mStep = 0; mRead = 0; mReads = 0; gap = 0; gapExp = 0;
      end
      vectors++;
      if (busy !== mBusy || done !== expDone || error !== expErr) begin
        fails++;
        $display("FAIL R9/R10 cycle %0d: busy=%b done=%b error=%b, expected busy=%b done=%b error=%b",
                 cyc, busy, done, error, mBusy, expDone, expErr);
      end
      if (mBusy) begin
        if (busReq && busAck) checkXfer();
        else if (!busReq) gap++;
      end else if (busReq) begin
        fails++;
        $display("FAIL R7/R10 cycle %0d: busReq=%b while idle, expected 0", cyc, busReq);
      end
      if (start && !mBusy) startPend = 1;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic runSeq(input logic [31:0] init, input int srstLag, input int gateLag,
                        input bit stall, input bit extraStart, input bit expErr, input string tag);
    int n;
    cfgInit = init; cfgSrstLag = srstLag; cfgGateLag = gateLag; stallMode = stall;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (extraStart) begin
      repeat (20) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    n = 0;
    @(negedge clk);
    while (!(done || error) && n < 8000) begin
      @(negedge clk); n++;
    end
    vectors++;
    if (error !== expErr || done !== !expErr) begin
      fails++;
      $display("FAIL %s outcome: done=%b error=%b, expected done=%b error=%b", tag, done, error, !expErr, expErr);
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      vectors++;
      if (busy !== 1'b0 || busReq !== 1'b0 || done !== 1'b0 || error !== 1'b0) begin
        fails++;
        $display("FAIL R10 after end: busy=%b busReq=%b done=%b error=%b, expected 0 0 0 0",
                 busy, busReq, done, error);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0 || error !== 1'b0 || busReq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: busy=%b done=%b error=%b busReq=%b, expected 0 0 0 0", busy, done, error, busReq);
    end
    @(posedge clk); #1 rstN = 1'b1;
    repeat (3) @(posedge clk);

    // R2 R3 R4 R5 R11: plain run, short lags
    runSeq(32'hC000_0000, 3, 5, 1'b0, 1'b0, 1'b0, "R5");
    // R8: stalled acknowledges
    runSeq(32'h8000_0000, 7, 2, 1'b1, 1'b0, 1'b0, "R8");
    // R10: start while busy is ignored
    runSeq(32'h4000_0000, 0, 0, 1'b0, 1'b1, 1'b0, "R10");
    // R6: condition met on the last allowed read
    runSeq(32'hC000_0000, TB_POLL - 1, 1, 1'b0, 1'b0, 1'b0, "R6");
    // R7: soft-reset bit never clears in time
    runSeq(32'hC000_0000, TB_POLL, 0, 1'b0, 1'b0, 1'b1, "R7");
    // R7: clock gate never rises in step three
    runSeq(32'h0000_0000, 0, 2000, 1'b0, 1'b0, 1'b1, "R7");
    // R6: gate rises on the last allowed read, with stalls
    runSeq(32'h0000_0000, 2, TB_POLL - 1, 1'b1, 1'b0, 1'b0, "R6");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule